// File: doc/BRIEF.md
# Per-Interface Timeslot Allocator

This block tracks which timeslots are taken on each interface of a circuit switch. For every interface it keeps a map with one bit per timeslot. A clear bit marks a free slot and a set bit marks a slot in use. A connection controller sends single requests to it. Each request either takes one slot on an interface or gives a known slot back. When a connection needs several slots, the controller issues one take request per slot.

A take request names only an interface. The block reads that interface's map and chooses the lowest-numbered free slot. It marks that slot as used, writes the map back and returns the slot number. A give request names an interface and a slot. The block clears that bit, provided the slot is really in use. Every request takes the same number of cycles and ends with a one-cycle completion strobe. The strobe comes with one of two outcomes: the result is valid, or the no-free-slot flag or the bad-release flag is raised.

Top module: `slot_alloc_top`

## Requirements
- R1: After reset every slot on every interface is free, and `busy`, `done`, `no_slot` and `bad_free` are low. A take request issued after a reset returns slot 0.
- R2: A request is accepted at a rising edge where `req_valid` is high and `busy` is low. After acceptance `busy` is high for exactly one cycle. A request presented while `busy` is high is ignored and changes no map.
- R3: `done` is high for exactly one cycle, starting at the second rising edge after the accepting edge. `no_slot` and `bad_free` are only ever high together with `done`.
- R4: `req_index` is split into two fields: the interface number in the upper `IF_W` bits and the slot number in the lower `SLOT_W` bits. A take request (`req_free` = 0) returns on `slot_out` the lowest-numbered free slot of the named interface. The slot field is ignored on a take.
- R5: A slot returned by a take becomes used. A later take on the same interface returns the next free slot and never returns that slot again until it is given back.
- R6: A take on an interface whose slots are all used raises `no_slot` with `done` and returns slot 0. The map is left unchanged.
- R7: A give request (`req_free` = 1) on a used slot frees that slot and echoes the slot number on `slot_out`. The freed slot is again eligible to be taken, in lowest-first order.
- R8: A give request on a slot that is already free, or on a slot number of `NUM_SLOTS` or above, raises `bad_free` with `done`. It echoes the slot number and changes no map.
- R9: Every interface has its own map. A request on one interface never changes the outcome of a request on another interface.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_free | input | 1 | 0 = take a slot, 1 = give a slot back |
| req_index | input | IF_W+SLOT_W | {interface, slot} |
| busy | output | 1 | A request is in progress; new requests are ignored |
| done | output | 1 | One-cycle completion strobe |
| slot_out | output | SLOT_W | Slot taken, or slot named in a give request |
| no_slot | output | 1 | A take found no free slot |
| bad_free | output | 1 | A give named a free or out-of-range slot |

## Verification
The bench fills one interface completely, then takes once more. A design that wrapped around or grew its map past the last slot would return a number here instead of raising `no_slot`. It releases a slot twice and releases slot numbers past the end of the map. A design without the used-bit test would silently accept these, and a design that set the bit instead of clearing it would lose a slot. It frees a slot in the middle of a full map and expects that slot to come back first, which catches encoders that pick the highest free bit. It also holds `req_valid` across the busy cycle, which exposes a design that accepts a request twice and so takes two slots.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;
  typedef enum logic {
    OP_TAKE = 1'b0,
    OP_GIVE = 1'b1
  } slot_op_e;
endpackage

// File: rtl/slot_table.sv
module slot_table #(
  parameter int NUM_IF    = 64,
  parameter int NUM_SLOTS = 12,
  parameter int IF_W      = (NUM_IF > 1) ? $clog2(NUM_IF) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IF_W-1:0]      rd_if,
  output logic [NUM_SLOTS-1:0] rd_vec,
  input  logic                 wr_en,
  input  logic [IF_W-1:0]      wr_if,
  input  logic [NUM_SLOTS-1:0] wr_vec
);
  logic [NUM_SLOTS-1:0] maps [NUM_IF];

  // Reads past the last interface see a full map, so nothing can be taken there.
  generate
    if (NUM_IF == (1 << IF_W)) begin : g_full_range
      assign rd_vec = maps[rd_if];
    end else begin : g_partial_range
      assign rd_vec = (int'(rd_if) < NUM_IF) ? maps[rd_if] : '1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_IF; i++) maps[i] <= '0;
    end else if (wr_en && (int'(wr_if) < NUM_IF)) begin
      maps[wr_if] <= wr_vec;
    end
  end
endmodule

// File: rtl/slot_pick.sv
module slot_pick #(
  parameter int NUM_SLOTS = 12,
  parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [NUM_SLOTS-1:0] vec,
  output logic                 found,
  output logic [SLOT_W-1:0]    slot
);
  // Scan from the top down so that the lowest clear bit is the one kept.
  always_comb begin
    found = 1'b0;
    slot  = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!vec[i]) begin
        found = 1'b1;
        slot  = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/slot_ctrl.sv
module slot_ctrl
  import slot_alloc_pkg::*;
#(
  parameter int NUM_IF    = 64,
  parameter int NUM_SLOTS = 12,
  parameter int IF_W      = (NUM_IF > 1) ? $clog2(NUM_IF) : 1,
  parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_free,
  input  logic [IF_W+SLOT_W-1:0] req_index,
  output logic                   accept,
  output logic                   pend,
  output logic [IF_W-1:0]        cur_if,
  input  logic [NUM_SLOTS-1:0]   rd_vec,
  input  logic                   pick_found,
  input  logic [SLOT_W-1:0]      pick_slot,
  output logic                   wr_en,
  output logic [NUM_SLOTS-1:0]   wr_vec,
  output logic                   done,
  output logic [SLOT_W-1:0]      slot_out,
  output logic                   no_slot,
  output logic                   bad_free
);
  function automatic logic [NUM_SLOTS-1:0] slot_mask(input logic [SLOT_W-1:0] s);
    logic [NUM_SLOTS-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SLOTS; i++) m[i] = (SLOT_W'(i) == s);
    return m;
  endfunction

  function automatic logic slot_in_use(input logic [NUM_SLOTS-1:0] v,
                                       input logic [SLOT_W-1:0] s);
    return |(v & slot_mask(s));
  endfunction

  slot_op_e          cur_op;
  logic [SLOT_W-1:0] cur_slot;
  logic              if_ok, slot_ok, take_ok, give_ok;

  generate
    if (NUM_IF == (1 << IF_W)) begin : g_if_all
      assign if_ok = 1'b1;
    end else begin : g_if_cmp
      assign if_ok = int'(cur_if) < NUM_IF;
    end
    if (NUM_SLOTS == (1 << SLOT_W)) begin : g_slot_all
      assign slot_ok = 1'b1;
    end else begin : g_slot_cmp
      assign slot_ok = int'(cur_slot) < NUM_SLOTS;
    end
  endgenerate

  assign accept  = req_valid && !pend;
  assign take_ok = pend && (cur_op == OP_TAKE) && if_ok && pick_found;
  assign give_ok = pend && (cur_op == OP_GIVE) && if_ok && slot_ok
                   && slot_in_use(rd_vec, cur_slot);
  assign wr_en   = take_ok || give_ok;
  assign wr_vec  = take_ok ? (rd_vec | slot_mask(pick_slot))
                           : (rd_vec & ~slot_mask(cur_slot));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      cur_op   <= OP_TAKE;
      cur_if   <= '0;
      cur_slot <= '0;
      done     <= 1'b0;
      slot_out <= '0;
      no_slot  <= 1'b0;
      bad_free <= 1'b0;
    end else begin
      pend <= accept;
      if (accept) begin
        cur_op   <= req_free ? OP_GIVE : OP_TAKE;
        cur_if   <= req_index[IF_W+SLOT_W-1:SLOT_W];
        cur_slot <= req_index[SLOT_W-1:0];
      end
      done     <= pend;
      no_slot  <= pend && (cur_op == OP_TAKE) && !take_ok;
      bad_free <= pend && (cur_op == OP_GIVE) && !give_ok;
      if (pend) slot_out <= (cur_op == OP_GIVE) ? cur_slot
                          : (take_ok ? pick_slot : '0);
    end
  end
endmodule

// File: rtl/slot_alloc_top.sv
module slot_alloc_top #(
  parameter int NUM_IF    = 64,
  parameter int NUM_SLOTS = 12,
  parameter int IF_W      = (NUM_IF > 1) ? $clog2(NUM_IF) : 1,
  parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_free,
  input  logic [IF_W+SLOT_W-1:0] req_index,
  output logic                   busy,
  output logic                   done,
  output logic [SLOT_W-1:0]      slot_out,
  output logic                   no_slot,
  output logic                   bad_free
);
  logic                 accept, pend, wr_en, pick_found;
  logic [IF_W-1:0]      cur_if;
  logic [NUM_SLOTS-1:0] rd_vec, wr_vec;
  logic [SLOT_W-1:0]    pick_slot;

  assign busy = pend;

  slot_table #(.NUM_IF(NUM_IF), .NUM_SLOTS(NUM_SLOTS), .IF_W(IF_W)) u_table (
    .clk(clk), .rst_n(rst_n), .rd_if(cur_if), .rd_vec(rd_vec),
    .wr_en(wr_en), .wr_if(cur_if), .wr_vec(wr_vec)
  );

  slot_pick #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_pick (
    .vec(rd_vec), .found(pick_found), .slot(pick_slot)
  );

  slot_ctrl #(.NUM_IF(NUM_IF), .NUM_SLOTS(NUM_SLOTS), .IF_W(IF_W), .SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_free(req_free),
    .req_index(req_index), .accept(accept), .pend(pend), .cur_if(cur_if),
    .rd_vec(rd_vec), .pick_found(pick_found), .pick_slot(pick_slot),
    .wr_en(wr_en), .wr_vec(wr_vec), .done(done), .slot_out(slot_out),
    .no_slot(no_slot), .bad_free(bad_free)
  );
endmodule

// File: rtl/slot_alloc_chk.sv
module slot_alloc_chk #(
  parameter int NUM_SLOTS = 12,
  parameter int SLOT_W    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 accept,
  input logic                 pend,
  input logic                 wr_en,
  input logic [NUM_SLOTS-1:0] rd_vec,
  input logic [NUM_SLOTS-1:0] wr_vec,
  input logic                 done,
  input logic [SLOT_W-1:0]    slot_out,
  input logic                 no_slot,
  input logic                 bad_free
);
  assert_busy_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> !pend);

  assert_done_follows_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 done);

  assert_done_has_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(pend));

  assert_flags_need_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (no_slot || bad_free) |-> done);

  assert_one_bit_changes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($countones(wr_vec ^ rd_vec) == 1));

  assert_write_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (done && !no_slot && !bad_free));

  assert_refusal_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !wr_en) |=> (no_slot || bad_free));

  assert_taken_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !no_slot && !bad_free) |-> (int'(slot_out) < NUM_SLOTS));
endmodule

bind slot_alloc_top slot_alloc_chk #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .pend(pend), .wr_en(wr_en),
  .rd_vec(rd_vec), .wr_vec(wr_vec), .done(done), .slot_out(slot_out),
  .no_slot(no_slot), .bad_free(bad_free)
);

// File: tb/tb_slot_alloc_top.sv
`timescale 1ns/1ps
module tb_slot_alloc_top;
  localparam int IF_W = 6;
  localparam int SLOT_W = 4;
  localparam int NV = 30;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, req_free = 1'b0;
  logic [IF_W+SLOT_W-1:0] req_index = '0;
  logic busy, done, no_slot, bad_free;
  logic [SLOT_W-1:0] slot_out;
  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  slot_alloc_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_free(req_free),
    .req_index(req_index), .busy(busy), .done(done), .slot_out(slot_out),
    .no_slot(no_slot), .bad_free(bad_free)
  );

  // {give, interface[5:0], slot[3:0], expected slot[3:0], expect no_slot, expect bad_free}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 6'd3, 4'd0,  4'd0,  1'b0, 1'b0},  // R4 first take
    {1'b0, 6'd3, 4'd15, 4'd1,  1'b0, 1'b0},  // R4 slot field ignored
    {1'b0, 6'd3, 4'd0,  4'd2,  1'b0, 1'b0},  // R5
    {1'b0, 6'd3, 4'd7,  4'd3,  1'b0, 1'b0},
    {1'b0, 6'd3, 4'd0,  4'd4,  1'b0, 1'b0},
    {1'b0, 6'd3, 4'd0,  4'd5,  1'b0, 1'b0},
    {1'b0, 6'd3, 4'd0,  4'd6,  1'b0, 1'b0},
    {1'b0, 6'd3, 4'd0,  4'd7,  1'b0, 1'b0},
    {1'b0, 6'd3, 4'd0,  4'd8,  1'b0, 1'b0},
    {1'b0, 6'd3, 4'd0,  4'd9,  1'b0, 1'b0},
    {1'b0, 6'd3, 4'd0,  4'd10, 1'b0, 1'b0},
    {1'b0, 6'd3, 4'd0,  4'd11, 1'b0, 1'b0},  // R5 last slot
    {1'b0, 6'd3, 4'd0,  4'd0,  1'b1, 1'b0},  // R6 full
    {1'b1, 6'd3, 4'd5,  4'd5,  1'b0, 1'b0},  // R7 free middle
    {1'b0, 6'd3, 4'd9,  4'd5,  1'b0, 1'b0},  // R7 freed slot again
    {1'b1, 6'd3, 4'd5,  4'd5,  1'b0, 1'b0},  // R7
    {1'b1, 6'd3, 4'd5,  4'd5,  1'b0, 1'b1},  // R8 double free
    {1'b1, 6'd3, 4'd13, 4'd13, 1'b0, 1'b1},  // R8 beyond map
    {1'b1, 6'd3, 4'd12, 4'd12, 1'b0, 1'b1},  // R8 first out-of-range
    {1'b0, 6'd7, 4'd0,  4'd0,  1'b0, 1'b0},  // R9 other interface
    {1'b0, 6'd7, 4'd0,  4'd1,  1'b0, 1'b0},  // R9
    {1'b1, 6'd7, 4'd0,  4'd0,  1'b0, 1'b0},  // R7
    {1'b0, 6'd7, 4'd0,  4'd0,  1'b0, 1'b0},  // R7 lowest first
    {1'b0, 6'd3, 4'd0,  4'd5,  1'b0, 1'b0},  // R9 interface 3 kept state
    {1'b0, 6'd3, 4'd0,  4'd0,  1'b1, 1'b0},  // R6 full again
    {1'b0, 6'd63, 4'd0, 4'd0,  1'b0, 1'b0},  // R9 top interface
    {1'b0, 6'd0, 4'd0,  4'd0,  1'b0, 1'b0},  // R9 bottom interface
    {1'b1, 6'd0, 4'd3,  4'd3,  1'b0, 1'b1},  // R8 never taken
    {1'b1, 6'd3, 4'd11, 4'd11, 1'b0, 1'b0},  // R7 free top slot
    {1'b0, 6'd3, 4'd0,  4'd11, 1'b0, 1'b0}   // R6 map unchanged by refusals
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic give, input logic [IF_W-1:0] ifn,
                        input logic [SLOT_W-1:0] sl, input logic [SLOT_W-1:0] es,
                        input logic enos, input logic ebad, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_free = give; req_index = {ifn, sl};
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R2", "busy after accept", int'(busy), 1);
    @(negedge clk);
    check(done == 1'b1, "R3", "done strobe", int'(done), 1);
    check(no_slot == enos, req, "no_slot", int'(no_slot), int'(enos));
    check(bad_free == ebad, req, "bad_free", int'(bad_free), int'(ebad));
    check(slot_out == es, req, "slot_out", int'(slot_out), int'(es));
  endtask

  task automatic reset_check;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check({busy, done, no_slot, bad_free} == 4'b0, "R1", "outputs in reset",
          int'({busy, done, no_slot, bad_free}), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    reset_check();
    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][16], VEC[i][15:10], VEC[i][9:6], VEC[i][5:2], VEC[i][1], VEC[i][0],
             VEC[i][16] ? "R7/R8" : "R4/R5/R6");
    end

    // R2: valid held across the busy cycle gives exactly one take
    @(negedge clk);
    req_valid = 1'b1; req_free = 1'b0; req_index = {6'd10, 4'd0};
    @(negedge clk);
    check(busy == 1'b1, "R2", "busy with valid held", int'(busy), 1);
    @(negedge clk);
    req_valid = 1'b0;
    check(done == 1'b1 && slot_out == 4'd0, "R2", "held take result",
          int'(slot_out), 0);
    @(negedge clk);
    check(done == 1'b0, "R3", "done single cycle", int'(done), 0);
    check(busy == 1'b0, "R2", "no second accept", int'(busy), 0);
    run_op(1'b0, 6'd10, 4'd0, 4'd1, 1'b0, 1'b0, "R2");

    // R1: reset frees every map
    reset_check();
    run_op(1'b0, 6'd3, 4'd0, 4'd0, 1'b0, 1'b0, "R1");
    run_op(1'b0, 6'd10, 4'd0, 4'd0, 1'b0, 1'b0, "R1");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule